// File: doc/BRIEF.md
# CCD Summing-Gate and Reset Clock Generator

This block generates four timing signals for the output end of a two-phase CCD shift register. The first is the summing-gate clock for the last register gate. The second is the reset clock for the sense node. The last two are the clamp and sample strobes that an external correlated-double-sampling stage uses. It runs on a master clock at eight times the element rate. It watches the phase-2 clock that the line sequencer produces and places each edge on one of eight sub-element slots. Slot 0 is the first master cycle in which phase 2 is seen high.

The block has two modes. In full-resolution mode the summing gate copies phase 2, and every element gets one reset, one clamp and one sample. In two-pixel binning mode the summing gate runs at half the phase-2 rate with a 75% high time. Two adjacent charge packets therefore merge under the gate before they are dumped onto the sense node together. Reset, clamp and sample then fire once per pair, so a 2098-element line yields 1049 outputs. The mode is taken from a select input only on a line-start pulse, so a line never mixes modes.

Top module: `ccd_sum_reset_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with phase 2 low, the summing gate, reset clock, clamp and sample are all low, and full-resolution mode is selected.
- R2: In full-resolution mode the summing gate equals the phase-2 input in every master cycle.
- R3: An element is 8 master cycles with phase 2 high in slots 0..3 and low in slots 4..7. In full-resolution mode the reset clock is high for exactly one cycle per element, in slot 1.
- R4: In full-resolution mode the clamp is high only in slot 3, the last cycle before phase 2 falls. The sample is high only in slot 7, the last cycle before the next phase-2 rise. Each is one cycle wide, and the clamp comes two cycles after the reset.
- R5: In binning mode the summing gate is high in all slots of the first element of a pair and in slots 0..3 of the second element, and low in slots 4..7 of the second element. That gives 12 of 16 cycles high, with a falling edge together with the phase-2 fall of the second element.
- R6: In binning mode the reset (slot 1), clamp (slot 3) and sample (slot 7) fire only in the second element of each pair, and never in the first.
- R7: The mode select is captured only in the cycle of a line-start pulse. Changes of the select at any other time have no effect on any output.
- R8: The first element after a line-start pulse is the first of a pair, whatever the parity of the previous line.
- R9: Once slot 7 has passed and phase 2 stays low (sequencer stopped), no reset, clamp or sample fires, and in binning mode the summing gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 8x the element rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ph2_in | input | 1 | Phase-2 register clock from the line sequencer, synchronous to clk |
| line_start | input | 1 | One-cycle pulse, given while phase 2 is stopped, before a line |
| bin_sel | input | 1 | 1 selects two-pixel binning, 0 full resolution; sampled on line_start |
| sum_gate | output | 1 | Summing-gate clock for the last register gate |
| reset_gate | output | 1 | Sense-node reset clock |
| cds_clamp | output | 1 | Clamp strobe at the reset level |
| cds_sample | output | 1 | Sample strobe at the signal level |

## Verification
The assertions assume a well-formed phase-2 input. Every rise of phase 2 begins a new element only after the previous one has run through all eight slots. A line-start pulse arrives while the slot counter is idle, at least one cycle before the first rise. The bench keeps within these limits by construction. It builds every element as exactly four high and four low master cycles, and places each line-start pulse in an idle gap with a spare cycle after it. The randomness goes into line length, mode, and toggling of the select in the middle of a line.

// File: rtl/ccdsg_pkg.sv
package ccdsg_pkg;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_BIN2 = 1'b1
  } ccd_mode_e;

  typedef struct packed {
    logic rst;
    logic clamp;
    logic sample;
  } cds_strobe_t;

  // Strobe decode for one slot; fire gates the whole set.
  function automatic cds_strobe_t pick_strobes(input int unsigned slot,
                                               input int unsigned rs,
                                               input int unsigned cs,
                                               input int unsigned ss,
                                               input logic fire);
    cds_strobe_t st;
    st.rst    = fire && (slot == rs);
    st.clamp  = fire && (slot == cs);
    st.sample = fire && (slot == ss);
    return st;
  endfunction

  // Binned gate level: high through the first element of a pair,
  // high only in the first half of the second element.
  function automatic logic bin_gate_level(input logic second,
                                          input int unsigned slot,
                                          input int unsigned half);
    return !second || (slot < half);
  endfunction

endpackage

// File: rtl/ccdsg_slot_track.sv
module ccdsg_slot_track #(
  parameter int SLOTS = 8,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ph2_in,
  input  logic          line_start,
  output logic [SW-1:0] slot,
  output logic          pair,
  output logic          adv
);

  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  logic          ph2_q;
  logic [SW-1:0] slot_q;
  logic          pair_q;
  logic          arm_q;
  logic          rise;

  assign rise = ph2_in && !ph2_q;
  assign adv  = rise || (slot_q != LAST_SLOT);

  always_comb begin
    if (rise)      slot = '0;
    else if (adv)  slot = slot_q + SW'(1);
    else           slot = slot_q;
  end

  always_comb begin
    if (rise) pair = arm_q ? 1'b0 : !pair_q;
    else      pair = pair_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph2_q  <= 1'b0;
      slot_q <= LAST_SLOT;
      pair_q <= 1'b0;
      arm_q  <= 1'b1;
    end else begin
      ph2_q  <= ph2_in;
      slot_q <= slot;
      pair_q <= pair;
      arm_q  <= line_start || (arm_q && !rise);
    end
  end

  // Input rule: a new element starts only after the last slot (R3)
  p_elem_complete_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (slot_q == LAST_SLOT));

  // First element after a line start is the first of a pair (R8)
  p_line_pair_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && arm_q) |-> !pair);

endmodule

// File: rtl/ccdsg_mode_latch.sv
module ccdsg_mode_latch
  import ccdsg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_start,
  input  logic      bin_sel,
  output ccd_mode_e mode
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode <= MODE_FULL;
    else if (line_start) mode <= bin_sel ? MODE_BIN2 : MODE_FULL;
  end

endmodule

// File: rtl/ccdsg_wave.sv
module ccdsg_wave
  import ccdsg_pkg::*;
#(
  parameter int SLOTS       = 8,
  parameter int RST_SLOT    = 1,
  parameter int CLAMP_SLOT  = 3,
  parameter int SAMPLE_SLOT = 7,
  parameter bit BIN_EN      = 1'b1,
  localparam int SW   = $clog2(SLOTS),
  localparam int HALF = SLOTS / 2
) (
  input  logic          ph2_in,
  input  ccd_mode_e     mode,
  input  logic [SW-1:0] slot,
  input  logic          pair,
  input  logic          adv,
  output logic          sum_gate,
  output logic          reset_gate,
  output logic          cds_clamp,
  output logic          cds_sample
);

  cds_strobe_t st;
  logic        fire;
  logic        binned;

  generate
    if (BIN_EN) begin : g_bin
      assign binned = (mode == MODE_BIN2);
    end else begin : g_full_only
      assign binned = 1'b0;
    end
  endgenerate

  // In binning, only the second element of a pair is read out.
  assign fire = adv && (!binned || pair);

  always_comb begin
    st = pick_strobes(32'(slot), RST_SLOT, CLAMP_SLOT, SAMPLE_SLOT, fire);
  end

  always_comb begin
    if (binned) sum_gate = adv && bin_gate_level(pair, 32'(slot), HALF);
    else        sum_gate = ph2_in;
  end

  assign reset_gate = st.rst;
  assign cds_clamp  = st.clamp;
  assign cds_sample = st.sample;

endmodule

// File: rtl/ccd_sum_reset_gen.sv
module ccd_sum_reset_gen
  import ccdsg_pkg::*;
#(
  parameter int SLOTS       = 8,
  parameter int RST_SLOT    = 1,
  parameter int CLAMP_SLOT  = 3,
  parameter int SAMPLE_SLOT = 7,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ph2_in,
  input  logic line_start,
  input  logic bin_sel,
  output logic sum_gate,
  output logic reset_gate,
  output logic cds_clamp,
  output logic cds_sample
);

  logic [SW-1:0] slot;
  logic          pair;
  logic          adv;
  ccd_mode_e     mode;

  ccdsg_slot_track #(.SLOTS(SLOTS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph2_in     (ph2_in),
    .line_start (line_start),
    .slot       (slot),
    .pair       (pair),
    .adv        (adv)
  );

  ccdsg_mode_latch u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .bin_sel    (bin_sel),
    .mode       (mode)
  );

  ccdsg_wave #(
    .SLOTS       (SLOTS),
    .RST_SLOT    (RST_SLOT),
    .CLAMP_SLOT  (CLAMP_SLOT),
    .SAMPLE_SLOT (SAMPLE_SLOT),
    .BIN_EN      (1'b1)
  ) u_wave (
    .ph2_in     (ph2_in),
    .mode       (mode),
    .slot       (slot),
    .pair       (pair),
    .adv        (adv),
    .sum_gate   (sum_gate),
    .reset_gate (reset_gate),
    .cds_clamp  (cds_clamp),
    .cds_sample (cds_sample)
  );

  p_full_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FULL) |-> (sum_gate == ph2_in));

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reset_gate, cds_clamp, cds_sample}));

  p_clamp_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cds_clamp |=> !cds_clamp);

  p_reset_then_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cds_clamp |-> $past(reset_gate, 2));

  p_sample_low_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cds_sample |-> !ph2_in);

  p_bin_second_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_BIN2) && (reset_gate || cds_sample)) |-> pair);

  p_mode_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(!adv));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> !(reset_gate || cds_clamp || cds_sample));

  p_idle_gate_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && (mode == MODE_BIN2)) |-> !sum_gate);

endmodule

// File: tb/ccd_sum_reset_gen_test.sv
module ccd_sum_reset_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 8;
  localparam int HALF       = SLOTS / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ph2_in = 1'b0;
  logic line_start = 1'b0;
  logic bin_sel = 1'b0;
  logic sum_gate, reset_gate, cds_clamp, cds_sample;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit exp_bin = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccd_sum_reset_gen uut (
    .clk(clk), .rst_n(rst_n), .ph2_in(ph2_in), .line_start(line_start),
    .bin_sel(bin_sel), .sum_gate(sum_gate), .reset_gate(reset_gate),
    .cds_clamp(cds_clamp), .cds_sample(cds_sample)
  );

  // Bench-side timing rules, written from the requirements
  function automatic bit exp_sg(bit bin, bit second, int s, bit ph2, bit live);
    if (!bin) return ph2;
    if (!live) return 1'b0;
    return second ? (s < HALF) : 1'b1;
  endfunction

  function automatic bit readout_elem(bit bin, bit second, bit live);
    return live && (!bin || second);
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(bit ph2, bit ls, bit sel, int s, bit second, bit live, bit flipped);
    string tg, ts;
    bit rd;
    @(negedge clk);
    ph2_in = ph2; line_start = ls; bin_sel = sel;
    #1;
    rd = readout_elem(exp_bin, second, live);
    if (!live)        tg = exp_bin ? "R9" : "R2";
    else if (flipped) tg = "R7";
    else              tg = exp_bin ? "R5" : "R2";
    ts = !live ? "R9" : (flipped ? "R7" : (exp_bin ? "R6" : "R4"));
    chk(tg, "sum_gate", sum_gate, exp_sg(exp_bin, second, s, ph2, live));
    chk((live && !exp_bin && !flipped) ? "R3" : ts, "reset_gate", reset_gate, rd && s == 1);
    chk(ts, "cds_clamp", cds_clamp, rd && s == 3);
    chk(ts, "cds_sample", cds_sample, rd && s == 7);
    if (ls) exp_bin = sel;
  endtask

  // One line: line_start in an idle gap, n elements, idle tail
  task automatic run_line(bit bin, int n, bit flip);
    bit sel;
    step(1'b0, 1'b1, bin, 7, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, bin, 7, 1'b0, 1'b0, 1'b0);
    for (int e = 0; e < n; e++) begin
      for (int s = 0; s < SLOTS; s++) begin
        sel = flip ? 1'($urandom_range(0, 1)) : bin;
        step(s < HALF, 1'b0, sel, s, 1'(e % 2), 1'b1, flip);
      end
    end
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, bin, 7, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D2C_3B4A));
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs quiet while reset is held
    chk("R1", "sum_gate", sum_gate, 1'b0);
    chk("R1", "reset_gate", reset_gate, 1'b0);
    chk("R1", "cds_clamp", cds_clamp, 1'b0);
    chk("R1", "cds_sample", cds_sample, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "sum_gate", sum_gate, 1'b0);
    chk("R1", "reset_gate", reset_gate, 1'b0);
    chk("R1", "cds_sample", cds_sample, 1'b0);

    // Directed: full resolution, binning even and odd, pair restart (R8)
    run_line(1'b0, 3, 1'b0);
    run_line(1'b1, 4, 1'b0);
    run_line(1'b1, 3, 1'b0);
    run_line(1'b1, 2, 1'b0);   // R8: previous line ended on a first element
    run_line(1'b0, 2, 1'b1);   // R7: select toggles mid-line
    run_line(1'b1, 4, 1'b1);   // R7
    run_line(1'b0, 1, 1'b0);

    // Random lines
    for (int i = 0; i < 40; i++)
      run_line(1'($urandom_range(0, 1)), $urandom_range(1, 8), 1'($urandom_range(0, 1)));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule